// File: doc/BRIEF.md
# Serial Register Access Slave (3-wire / 4-wire)

This block lets an external host read and write a bank of 16-bit configuration registers over a slow serial link. The host frames each access by pulling an active-low select input low. It then clocks in an instruction byte followed by a 16-bit data phase. The instruction byte carries a direction bit and a 7-bit register address. On a write, the block stores the data word and pulses a write strobe toward the rest of the chip. On a read, it shifts the addressed register back out, most significant bit first.

Read data leaves on one of two pins. In 3-wire operation it shares the data pin that also carries host input. In 4-wire operation it uses a dedicated output pin. A bit in one of the block's own registers selects the mode, so software can switch it with an ordinary write. Both pins are modelled as a value plus an output enable, and the pad drivers sit outside the block.

The serial pins are sampled by the system clock through synchronisers. All edge handling is therefore synchronous to that clock, and every output is a register. The serial clock must be several system clocks slower than the system clock.

Top module: `scfg_serial_slave`

## Requirements
- R1: A frame starts when `cs_n` falls. Bit 7 of the instruction byte, received first, selects the direction: 1 is a read and 0 is a write. Bits 6 to 0 follow MSB first and give the register address. Exactly 16 data bits follow, MSB first.
- R2: A write frame that delivers all 16 data bits to an implemented address stores the word. It also pulses `cfg_wr_stb` for one clock with that address on `cfg_wr_addr` and that word on `cfg_wr_data`.
- R3: If `cs_n` rises before the 16th data bit has been sampled, nothing is stored and no strobe is issued. The next frame decodes from its first bit.
- R4: On a read, the addressed register is captured when the instruction byte completes. It is shifted out MSB first. Data bit 15 is driven after the falling `sclk` edge that follows the 8th rising edge, and one bit follows each later falling edge.
- R5: In 3-wire mode, read data appears on `sdio_out` with `sdio_oe` high during the data phase. `sdo_oe` stays low until the end-of-transfer state.
- R6: In 4-wire mode, read data appears on `sdo_out` with `sdo_oe` high during the data phase. `sdio_oe` stays low until the end-of-transfer state.
- R7: After the falling edge that follows the 24th rising edge, both `sdio_oe` and `sdo_oe` are high and both data outputs are 0. This holds until `cs_n` rises. Then both enables drop to 0.
- R8: Bit 0 of register address 3 selects the mode: 0 is 3-wire and 1 is 4-wire. It resets to 0. A write to it takes effect from the next frame.
- R9: Addresses 32 to 127 are unimplemented. They read back as zero, and writes to them store nothing and issue no strobe.
- R10: After reset, all registers hold zero, both output enables are low and no strobe is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdio_in | input | 1 | Shared data pin, input side |
| sdio_out | output | 1 | Shared data pin, output value |
| sdio_oe | output | 1 | Shared data pin, output enable |
| sdo_out | output | 1 | Dedicated output pin value |
| sdo_oe | output | 1 | Dedicated output pin enable |
| cfg_wr_stb | output | 1 | One-clock pulse on a committed write |
| cfg_wr_addr | output | 7 | Address of the committed write |
| cfg_wr_data | output | 16 | Data of the committed write |

## Verification
The hardest condition to reach from the pins is a mode change written by the host itself. The frame that writes the mode bit must still run in the old mode, and the very next read must come out on the other pin. The bench therefore writes the mode register through the serial link and immediately follows with a read. On every data bit it checks which enable is active. It then switches back the same way. Aborted frames are made by raising `cs_n` after 12 bits, and the bench then reads the same address to show nothing was stored.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  typedef enum logic {
    WIRE3 = 1'b0,
    WIRE4 = 1'b1
  } wire_mode_e;
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  logic [W-1:0] stg [STAGES+1];

  generate
    for (genvar s = 0; s <= STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q   = stg[STAGES-1];
  assign q_d = stg[STAGES];
endmodule

// File: rtl/scfg_frame.sv
module scfg_frame
  import scfg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  localparam int INSTR_BITS = ADDR_W + 1,
  localparam int FRAME_BITS = INSTR_BITS + DATA_W,
  localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              cs_act,
  input  logic              cs_start,
  input  logic              cs_end,
  input  logic              sdi,
  input  logic              mode_bit,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              is_read,
  output wire_mode_e        mode_frame,
  output logic              rd_req,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data
);
  localparam logic [CNT_W-1:0] LAST_INSTR = CNT_W'(INSTR_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] END_CNT    = CNT_W'(FRAME_BITS);

  logic [DATA_W-1:0] sh;
  logic              take_bit;

  assign take_bit = sclk_rise && cs_act && (bit_cnt < END_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      is_read    <= 1'b0;
      mode_frame <= WIRE3;
      rd_req     <= 1'b0;
      acc_addr   <= '0;
      wr_en      <= 1'b0;
      wr_data    <= '0;
      sh         <= '0;
    end else begin
      rd_req <= 1'b0;
      wr_en  <= 1'b0;
      if (cs_end) begin
        bit_cnt <= '0;
        is_read <= 1'b0;
      end else if (cs_start) begin
        bit_cnt    <= '0;
        is_read    <= 1'b0;
        mode_frame <= wire_mode_e'(mode_bit);
      end else if (take_bit) begin
        bit_cnt <= bit_cnt + 1'b1;
        sh      <= {sh[DATA_W-2:0], sdi};
        if (bit_cnt == LAST_INSTR) begin
          is_read  <= sh[ADDR_W-1];
          acc_addr <= {sh[ADDR_W-2:0], sdi};
          rd_req   <= sh[ADDR_W-1];
        end
        if (bit_cnt == LAST_DATA && !is_read) begin
          wr_en   <= 1'b1;
          wr_data <= {sh[DATA_W-2:0], sdi};
        end
      end
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= END_CNT);
  assert_commit_full_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (bit_cnt == END_CNT && !is_read));
  assert_abort_clears_R3: assert property (@(posedge clk) disable iff (rst)
    cs_end |=> (bit_cnt == '0));
  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !cs_start) |=> $stable(mode_frame));
endmodule

// File: rtl/scfg_regbank.sv
module scfg_regbank #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 16,
  parameter int NUM_REGS  = 32,
  parameter int MODE_ADDR = 3,
  parameter int MODE_BIT  = 0,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              mode_bit,
  output logic              stb,
  output logic [ADDR_W-1:0] stb_addr,
  output logic [DATA_W-1:0] stb_data
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic              in_range;
  logic [IDX_W-1:0]  idx;

  assign in_range = (int'(addr) < NUM_REGS);
  assign idx      = IDX_W'(addr);

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)                                       regs[r] <= '0;
        else if (wr_en && in_range && int'(idx) == r)  regs[r] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_vld   <= 1'b0;
      stb      <= 1'b0;
      stb_addr <= '0;
      stb_data <= '0;
    end else begin
      rd_vld <= rd_req;
      if (rd_req) rd_data <= in_range ? regs[idx] : '0;
      stb <= wr_en && in_range;
      if (wr_en && in_range) begin
        stb_addr <= addr;
        stb_data <= wr_data;
      end
    end
  end

  assign mode_bit = regs[MODE_ADDR][MODE_BIT];

  assert_rd_follow_R4: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_vld);
  assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && int'(addr) >= NUM_REGS) |=> (rd_data == '0));
  assert_unimpl_nostb_R9: assert property (@(posedge clk) disable iff (rst)
    stb |-> (int'(stb_addr) < NUM_REGS));
endmodule

// File: rtl/scfg_outdrv.sv
module scfg_outdrv
  import scfg_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int INSTR_BITS = 8,
  localparam int FRAME_BITS = INSTR_BITS + DATA_W,
  localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_fall,
  input  logic             cs_act,
  input  logic             cs_end,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             is_read,
  input  wire_mode_e       mode_frame,
  input  logic             ld,
  input  logic [DATA_W-1:0] ld_data,
  output logic             sdio_o,
  output logic             sdio_oe,
  output logic             sdo_o,
  output logic             sdo_oe
);
  localparam logic [CNT_W-1:0] FIRST_OUT = CNT_W'(INSTR_BITS);
  localparam logic [CNT_W-1:0] END_CNT   = CNT_W'(FRAME_BITS);

  logic [DATA_W-1:0] shreg;
  logic              data_phase;

  assign data_phase = is_read && (bit_cnt >= FIRST_OUT) && (bit_cnt < END_CNT);

  always_ff @(posedge clk) begin
    if (rst || cs_end) begin
      sdio_o  <= 1'b0;
      sdio_oe <= 1'b0;
      sdo_o   <= 1'b0;
      sdo_oe  <= 1'b0;
      shreg   <= '0;
    end else begin
      if (ld) shreg <= ld_data;
      if (sclk_fall && cs_act) begin
        if (bit_cnt == END_CNT) begin
          sdio_o  <= 1'b0;
          sdio_oe <= 1'b1;
          sdo_o   <= 1'b0;
          sdo_oe  <= 1'b1;
        end else if (data_phase) begin
          shreg <= {shreg[DATA_W-2:0], 1'b0};
          if (mode_frame == WIRE4) begin
            sdo_o  <= shreg[DATA_W-1];
            sdo_oe <= 1'b1;
          end else begin
            sdio_o  <= shreg[DATA_W-1];
            sdio_oe <= 1'b1;
          end
        end
      end
    end
  end

  assert_end_low_R7: assert property (@(posedge clk) disable iff (rst)
    (sdio_oe && sdo_oe) |-> (!sdio_o && !sdo_o));
  assert_release_R7: assert property (@(posedge clk) disable iff (rst)
    cs_end |=> (!sdio_oe && !sdo_oe));
  assert_3w_pin_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_frame == WIRE3 && sdo_oe) |-> sdio_oe);
  assert_4w_pin_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_frame == WIRE4 && sdio_oe) |-> sdo_oe);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (!sdio_oe && !sdo_oe));
endmodule

// File: rtl/scfg_serial_slave.sv
module scfg_serial_slave
  import scfg_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int NUM_REGS    = 32,
  parameter int MODE_ADDR   = 3,
  parameter int MODE_BIT    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic              sdo_out,
  output logic              sdo_oe,
  output logic              cfg_wr_stb,
  output logic [ADDR_W-1:0] cfg_wr_addr,
  output logic [DATA_W-1:0] cfg_wr_data
);
  localparam int INSTR_BITS = ADDR_W + 1;
  localparam int FRAME_BITS = INSTR_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic [2:0] pin_q, pin_qd;
  logic       sclk_rise, sclk_fall, cs_act, cs_start, cs_end, sdi;

  scfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({sdio_in, cs_n, sclk}),
    .q   (pin_q),
    .q_d (pin_qd)
  );

  assign sclk_rise = pin_q[0] & ~pin_qd[0];
  assign sclk_fall = ~pin_q[0] & pin_qd[0];
  assign cs_act    = ~pin_q[1];
  assign cs_start  = ~pin_q[1] & pin_qd[1];
  assign cs_end    = pin_q[1] & ~pin_qd[1];
  assign sdi       = pin_q[2];

  logic [CNT_W-1:0]  bit_cnt;
  logic              is_read, rd_req, wr_en, rd_vld, mode_bit;
  wire_mode_e        mode_frame;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  scfg_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .sclk_rise  (sclk_rise),
    .cs_act     (cs_act),
    .cs_start   (cs_start),
    .cs_end     (cs_end),
    .sdi        (sdi),
    .mode_bit   (mode_bit),
    .bit_cnt    (bit_cnt),
    .is_read    (is_read),
    .mode_frame (mode_frame),
    .rd_req     (rd_req),
    .acc_addr   (acc_addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data)
  );

  scfg_regbank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .MODE_ADDR(MODE_ADDR), .MODE_BIT(MODE_BIT)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .addr     (acc_addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_req   (rd_req),
    .rd_data  (rd_data),
    .rd_vld   (rd_vld),
    .mode_bit (mode_bit),
    .stb      (cfg_wr_stb),
    .stb_addr (cfg_wr_addr),
    .stb_data (cfg_wr_data)
  );

  scfg_outdrv #(.DATA_W(DATA_W), .INSTR_BITS(INSTR_BITS)) u_out (
    .clk        (clk),
    .rst        (rst),
    .sclk_fall  (sclk_fall),
    .cs_act     (cs_act),
    .cs_end     (cs_end),
    .bit_cnt    (bit_cnt),
    .is_read    (is_read),
    .mode_frame (mode_frame),
    .ld         (rd_vld),
    .ld_data    (rd_data),
    .sdio_o     (sdio_out),
    .sdio_oe    (sdio_oe),
    .sdo_o      (sdo_out),
    .sdo_oe     (sdo_oe)
  );
endmodule

// File: tb/scfg_serial_slave_bench.sv
module scfg_serial_slave_bench;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdio_in = 1'b0;
  logic        sdio_out, sdio_oe, sdo_out, sdo_oe, cfg_wr_stb;
  logic [6:0]  cfg_wr_addr;
  logic [15:0] cfg_wr_data;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;
  logic [6:0]  last_addr = '0;
  logic [15:0] last_data = '0;

  always #5 clk = ~clk;

  scfg_serial_slave u_scfg_serial_slave (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
    .cfg_wr_stb(cfg_wr_stb), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data)
  );

  always @(posedge clk) begin
    if (!rst && cfg_wr_stb) begin
      stb_cnt   <= stb_cnt + 1;
      last_addr <= cfg_wr_addr;
      last_data <= cfg_wr_data;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Runs one frame of nbits serial clocks. For reads, collects data from the
  // pin chosen by four_w and counts samples where the enables were wrong.
  task automatic run_frame(input bit rd, input logic [6:0] a, input logic [15:0] wd,
                           input int nbits, input bit four_w,
                           output logic [15:0] q, output int bad_oe);
    logic [23:0] bits;
    bits   = {rd, a, wd};
    q      = '0;
    bad_oe = 0;
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      sdio_in = rd && i >= 8 ? 1'b0 : bits[23-i];
      wait_clk(HALF);
      if (rd && i >= 8) begin
        q[15-(i-8)] = four_w ? sdo_out : sdio_out;
        if (four_w ? (!sdo_oe || sdio_oe) : (!sdio_oe || sdo_oe)) bad_oe++;
      end
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    if (nbits == 24) begin
      chk(sdio_oe && sdo_oe && !sdio_out && !sdo_out, "R7 end drive low",
          {sdio_oe, sdo_oe, sdio_out, sdo_out}, 4'b1100);
      wait_clk(2 * HALF);
      chk(sdio_oe && sdo_oe && !sdio_out && !sdo_out, "R7 low held until cs_n rises",
          {sdio_oe, sdo_oe, sdio_out, sdo_out}, 4'b1100);
    end
    cs_n = 1'b1;
    wait_clk(6);
    chk(!sdio_oe && !sdo_oe, "R7 release after cs_n", {sdio_oe, sdo_oe}, 2'b00);
    wait_clk(HALF);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [15:0] d);
    logic [15:0] q;
    int b;
    run_frame(1'b0, a, d, 24, 1'b0, q, b);
  endtask

  task automatic do_read(input logic [6:0] a, input bit four_w, output logic [15:0] q, output int b);
    run_frame(1'b1, a, 16'h0000, 24, four_w, q, b);
  endtask

  task automatic t_reset;
    chk(!sdio_oe && !sdo_oe, "R10 enables low after reset", {sdio_oe, sdo_oe}, 0);
    chk(!cfg_wr_stb && stb_cnt == 0, "R10 no strobe after reset", stb_cnt, 0);
  endtask

  task automatic t_write_read_3w;
    logic [15:0] q;
    int b, n0;
    n0 = stb_cnt;
    do_write(7'h05, 16'hA5C3);
    chk(stb_cnt == n0 + 1, "R2 one strobe per write", stb_cnt, n0 + 1);
    chk(last_addr == 7'h05, "R1 R2 strobe address", last_addr, 7'h05);
    chk(last_data == 16'hA5C3, "R1 R2 strobe data", last_data, 16'hA5C3);
    do_read(7'h05, 1'b0, q, b);
    chk(q == 16'hA5C3, "R4 read back MSB first on shared pin", q, 16'hA5C3);
    chk(b == 0, "R5 3-wire enables during data phase", b, 0);
    do_read(7'h07, 1'b0, q, b);
    chk(q == 16'h0000, "R10 unwritten register reads zero", q, 0);
  endtask

  task automatic t_abort;
    logic [15:0] q;
    int b, n0;
    n0 = stb_cnt;
    run_frame(1'b0, 7'h06, 16'hFFFF, 12, 1'b0, q, b);
    chk(stb_cnt == n0, "R3 aborted frame issues no strobe", stb_cnt, n0);
    do_read(7'h06, 1'b0, q, b);
    chk(q == 16'h0000, "R3 aborted frame stored nothing", q, 0);
    do_write(7'h06, 16'h1234);
    do_read(7'h06, 1'b0, q, b);
    chk(q == 16'h1234, "R3 frame after abort decodes cleanly", q, 16'h1234);
  endtask

  task automatic t_mode_switch;
    logic [15:0] q;
    int b;
    do_write(7'h03, 16'h0001);
    do_read(7'h05, 1'b1, q, b);
    chk(q == 16'hA5C3, "R6 R8 4-wire read on dedicated pin", q, 16'hA5C3);
    chk(b == 0, "R6 4-wire enables during data phase", b, 0);
    do_read(7'h03, 1'b1, q, b);
    chk(q == 16'h0001, "R8 mode register reads back", q, 16'h0001);
  endtask

  task automatic t_unimpl;
    logic [15:0] q;
    int b, n0;
    n0 = stb_cnt;
    do_write(7'h50, 16'hBEEF);
    chk(stb_cnt == n0, "R9 unimplemented write no strobe", stb_cnt, n0);
    do_read(7'h50, 1'b1, q, b);
    chk(q == 16'h0000, "R9 unimplemented reads zero", q, 0);
    do_read(7'h7F, 1'b1, q, b);
    chk(q == 16'h0000, "R9 top address reads zero", q, 0);
  endtask

  task automatic t_back_to_3w;
    logic [15:0] q;
    int b;
    do_write(7'h03, 16'h0000);
    do_read(7'h06, 1'b0, q, b);
    chk(q == 16'h1234, "R8 back to 3-wire data", q, 16'h1234);
    chk(b == 0, "R5 R8 back to 3-wire enables", b, 0);
    do_write(7'h1F, 16'h8001);
    do_read(7'h1F, 1'b0, q, b);
    chk(q == 16'h8001, "R1 last implemented address", q, 16'h8001);
  endtask

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    t_reset();
    t_write_read_3w();
    t_abort();
    t_mode_switch();
    t_unimpl();
    t_back_to_3w();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule